// File: doc/BRIEF.md
# SPI Master Transfer Sequencer

This block is the shifting engine of a master-mode SPI controller. It takes 8-bit words from a transmit queue through a pop/valid handshake and sends each one MSB first on MOSI under a mode-0 serial clock (idle low, sample on the rising edge, change on the falling edge). At the same time it collects the bits arriving on MISO and hands each finished word to a receive queue with a one-cycle push strobe.

The first word taken from an idle queue waits out a fixed start-up latency. This stands in for the crossing from the register-bus clock into the peripheral clock: one bus cycle plus six peripheral cycles. Each word goes into a shift register and leaves through a single output skew flop. When further words are queued, the engine fetches them itself. Between two words it holds SCLK low for a programmable number of whole SCLK periods. A setting of zero streams the words with no break. Slave select stays low over the whole burst and rises only when the queue is empty at the last falling edge of a word.

Top module: `spi_seq_top`

## Requirements
- R1: While and right after reset: ss_n=1, sclk=0, busy=0, tx_pop=0, rx_push=0.
- R2: If tx_valid is high at a clock edge while the engine is idle, ss_n falls and busy rises after that edge. tx_pop is high in the 7th cycle with ss_n low. SCLK stays low for 8+cfg_div cycles of the active phase before its first rising edge.
- R3: SCLK is high for cfg_div+1 clock cycles per bit. It is low for cfg_div+1 cycles between rising edges inside a word, and low whenever ss_n is high.
- R4: MOSI carries the word MSB first, one bit per SCLK rising edge. It is stable on every cycle with SCLK high and changes only after falling edges or at a load.
- R5: MISO is sampled on each SCLK rising edge. rx_push pulses for one cycle, in the cycle that ends with the word's 8th rising edge. rx_data then holds the 8 sampled bits, with the first sampled bit as bit 7.
- R6: SCLK is held low for (2*cfg_gap+1)*(cfg_div+1) cycles between the last falling edge of a word and the first rising edge of the next word in the same burst. cfg_gap=0 gives continuous streaming.
- R7: A word is consumed at a clock edge where tx_pop and tx_valid are both high. tx_pop is high only with tx_valid. Words queued while a word is shifting are sent in the same burst without releasing ss_n.
- R8: ss_n rises only after a final falling edge at which tx_valid was low. busy equals !ss_n in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | 4 | SCLK half period minus one, in clk cycles |
| cfg_gap | input | 4 | Idle gap between words, in SCLK periods |
| tx_valid | input | 1 | Transmit queue holds a word |
| tx_data | input | 8 | Head word of the transmit queue |
| tx_pop | output | 1 | Takes the head word at this edge |
| rx_push | output | 1 | Received word strobe |
| rx_data | output | 8 | Received word |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Slave select, active low |
| busy | output | 1 | Transaction active |

## Verification
The bench measures the SCLK low time before every rising edge. A start counter off by one, a gap counted in half periods instead of whole periods, or a continuous mode that still puts in one dead half period would each show up as a wrong low-run length. It queues a second word in the middle of a shift, so a design that releases ss_n between words, or drops a word that arrived late, fails the end-of-burst checks. It also checks that the received word appears together with the final sampled bit: a push one cycle late would carry a shifted word or miss the MISO bit.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    localparam int WORD_W   = 8;
    localparam int DIV_W    = 4;
    localparam int GAP_W    = 4;
    localparam int BUS_LAT  = 1;
    localparam int PCLK_LAT = 6;
    localparam int START_LAT = BUS_LAT + PCLK_LAT;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_SHIFT,
        ST_GAP
    } seq_state_t;

    // Commands from the sequencer to the datapath
    typedef struct packed {
        logic load;    // take a new word from the queue
        logic shift;   // advance the output after a falling edge
        logic sample;  // capture MISO at a rising edge
    } shift_cmd_t;

    // Index of the last half period in a gap of g whole SCLK periods
    function automatic logic [GAP_W:0] gap_last(input logic [GAP_W-1:0] g);
        return {g, 1'b0} - 1'b1;
    endfunction

endpackage

// File: rtl/spi_seq_halfdiv.sv
module spi_seq_halfdiv #(
    parameter int DIV_W = spi_seq_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] hcnt;

    assign tick = run && (hcnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) hcnt <= '0;
        else                     hcnt <= hcnt + 1'b1;
    end

    // R3: the half-period counter never passes the programmed limit
    a_r3_half_bound: assert property (@(posedge clk) disable iff (rst)
        (run && $stable(div)) |-> (hcnt <= div));

endmodule

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter
    import spi_seq_pkg::*;
#(
    parameter int W = spi_seq_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  shift_cmd_t   cmd,
    input  logic [W-1:0] load_word,
    input  logic         miso,
    output logic         mosi,
    output logic [W-1:0] rx_word
);
    logic [W-1:0] tx_sr;
    logic [W-1:0] rx_sr;
    logic         skew_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr  <= '0;
            skew_q <= 1'b0;
        end else if (cmd.load) begin
            skew_q <= load_word[W-1];
            tx_sr  <= load_word << 1;
        end else if (cmd.shift) begin
            skew_q <= tx_sr[W-1];
            tx_sr  <= tx_sr << 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             rx_sr <= '0;
        else if (cmd.sample) rx_sr <= {rx_sr[W-2:0], miso};
    end

    assign mosi    = skew_q;
    assign rx_word = {rx_sr[W-2:0], miso};

    // R4: a loaded word presents its MSB first
    a_r4_load_msb: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> (mosi == $past(load_word[W-1])));
    // R4: load and shift never compete
    a_r4_cmd_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd.load, cmd.shift}));

endmodule

// File: rtl/spi_seq_top.sv
module spi_seq_top
    import spi_seq_pkg::*;
#(
    parameter int WORD_W    = spi_seq_pkg::WORD_W,
    parameter int DIV_W     = spi_seq_pkg::DIV_W,
    parameter int GAP_W     = spi_seq_pkg::GAP_W,
    parameter int START_LAT = spi_seq_pkg::START_LAT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n,
    output logic              busy
);
    localparam int BIT_W   = $clog2(WORD_W + 1);
    localparam int LAT_W   = $clog2(START_LAT + 1);
    localparam int CNT_W   = (GAP_W + 1 > LAT_W) ? GAP_W + 1 : LAT_W;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W);
    localparam logic [BIT_W-1:0] PUSH_BIT = BIT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] LAT_END  = CNT_W'(START_LAT - 1);

    seq_state_t       st;
    logic [CNT_W-1:0] cnt;
    logic [BIT_W-1:0] bitcnt;
    logic             ph;

    logic       run, tick;
    logic       rise_ev, fall_ev, last_bit, final_ev;
    logic       start_done, gap_done, fetch;
    shift_cmd_t cmd;

    assign run = (st == ST_SHIFT) || (st == ST_GAP);

    spi_seq_halfdiv #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .div  (cfg_div),
        .tick (tick)
    );

    always_comb begin
        rise_ev    = (st == ST_SHIFT) && tick && !ph;
        fall_ev    = (st == ST_SHIFT) && tick &&  ph;
        last_bit   = (bitcnt == LAST_BIT);
        final_ev   = fall_ev && last_bit;
        start_done = (st == ST_START) && (cnt == LAT_END);
        gap_done   = (st == ST_GAP) && tick &&
                     (cnt == CNT_W'(gap_last(cfg_gap)));
        fetch      = tx_valid &&
                     (start_done || gap_done || (final_ev && cfg_gap == '0));
        cmd.load   = fetch;
        cmd.shift  = fall_ev && !last_bit;
        cmd.sample = rise_ev;
    end

    spi_seq_shifter #(.W(WORD_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .load_word (tx_data),
        .miso      (miso),
        .mosi      (mosi),
        .rx_word   (rx_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            bitcnt <= '0;
            ph     <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (tx_valid) begin
                        st  <= ST_START;
                        cnt <= '0;
                    end
                end
                ST_START: begin
                    cnt <= cnt + 1'b1;
                    if (start_done) begin
                        st     <= tx_valid ? ST_SHIFT : ST_IDLE;
                        ph     <= 1'b0;
                        bitcnt <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (rise_ev) begin
                        ph     <= 1'b1;
                        bitcnt <= bitcnt + 1'b1;
                    end
                    if (fall_ev) begin
                        ph <= 1'b0;
                        if (last_bit) begin
                            bitcnt <= '0;
                            if (!tx_valid) begin
                                st <= ST_IDLE;
                            end else if (cfg_gap != '0) begin
                                st  <= ST_GAP;
                                cnt <= '0;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        cnt <= cnt + 1'b1;
                        if (gap_done) st <= tx_valid ? ST_SHIFT : ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign tx_pop  = fetch;
    assign rx_push = rise_ev && (bitcnt == PUSH_BIT);
    assign sclk    = (st == ST_SHIFT) && ph;
    assign ss_n    = (st == ST_IDLE);
    assign busy    = (st != ST_IDLE);

    // R7: the queue is popped only when it holds a word
    a_r7_pop_needs_valid: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> tx_valid);
    // R8: select is released only after an empty queue at the final edge
    a_r8_release_empty: assert property (@(posedge clk) disable iff (rst)
        $rose(ss_n) |-> !$past(tx_valid));
    // R5: the push strobe precedes the 8th rising edge
    a_r5_push_then_rise: assert property (@(posedge clk) disable iff (rst)
        rx_push |=> $rose(sclk));
    // R4: MOSI holds while SCLK is high
    a_r4_mosi_hold: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(mosi));
    // R2: select falls with the clock low and before any fetch
    a_r2_select_first: assert property (@(posedge clk) disable iff (rst)
        $fell(ss_n) |-> (!sclk && !tx_pop));

endmodule

// File: tb/spi_seq_top_bench.sv
module spi_seq_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] cfg_div = '0;
    logic [3:0] cfg_gap = '0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_pop, rx_push, sclk, mosi, ss_n, busy;
    logic [7:0] rx_data;
    logic       miso = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    spi_seq_top u_spi_seq_top (
        .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_gap(cfg_gap),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_data), .sclk(sclk), .mosi(mosi),
        .miso(miso), .ss_n(ss_n), .busy(busy)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0, run_mon = 0;

    logic [7:0] q [0:255];
    int wr = 0, rd = 0;
    int idle_cnt = 0;
    int tx_k = 0, rx_k = 0;
    int mismatch = 0;

    function automatic logic [7:0] slave_word(input int k);
        return 8'((k * 37 + 91) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Queue model, slave model and monitor
    initial begin
        bit   pend_pop = 0;
        bit   prev_sclk = 0, prev_ss = 1, first = 0, pop_seen = 0;
        int   low_run = 0, high_run = 0, act_cnt = 0, bit_i = 0, exp_low;
        logic [7:0] mo_word = '0;
        logic [7:0] sw;
        wait (run_mon);
        forever begin
            @(negedge clk);
            if (pend_pop) rd++;
            tx_valid = (rd < wr);
            tx_data  = q[rd % 256];
            sw       = slave_word(tx_k);
            miso     = sw[7 - bit_i];
            #1;
            pend_pop = tx_pop;
            if (busy !== !ss_n) mismatch++;
            if (ss_n && sclk) mismatch++;
            if (!ss_n) begin
                if (prev_ss) begin
                    act_cnt = 0; first = 1; pop_seen = 0;
                    low_run = 0; high_run = 0; bit_i = 0;
                end
                act_cnt++;
                if (tx_pop && !pop_seen) begin
                    pop_seen = 1;
                    chk(act_cnt == 7, "R2", "first pop cycle", act_cnt, 7);
                end
                if (rx_push) begin
                    chk(rx_data == slave_word(rx_k), "R5", "rx word",
                        rx_data, slave_word(rx_k));
                    chk(!sclk && bit_i == 7, "R5", "push position", bit_i, 7);
                    rx_k++;
                end
                if (!sclk) begin
                    if (prev_sclk)
                        chk(high_run == cfg_div + 1, "R3", "high time",
                            high_run, cfg_div + 1);
                    low_run++;
                    high_run = 0;
                end else begin
                    if (!prev_sclk) begin
                        if (first && bit_i == 0)  exp_low = 8 + cfg_div;
                        else if (bit_i == 0)      exp_low = (2 * cfg_gap + 1) * (cfg_div + 1);
                        else                      exp_low = cfg_div + 1;
                        chk(low_run == exp_low,
                            (first && bit_i == 0) ? "R2" : (bit_i == 0 ? "R6" : "R3"),
                            "low time before rise", low_run, exp_low);
                        mo_word = {mo_word[6:0], mosi};
                        bit_i++;
                        if (bit_i == 8) begin
                            chk(mo_word == q[tx_k % 256], "R4", "mosi word",
                                mo_word, q[tx_k % 256]);
                            tx_k++;
                            bit_i = 0;
                            first = 0;
                        end
                    end
                    high_run++;
                    low_run = 0;
                end
            end else if (!prev_ss) begin
                chk(rd == wr && bit_i == 0, "R8", "release with queue empty",
                    wr - rd, 0);
                chk(high_run == cfg_div + 1, "R8", "release after final edge",
                    high_run, cfg_div + 1);
            end
            if (ss_n && rd == wr) idle_cnt++;
            else                  idle_cnt = 0;
            prev_sclk = sclk;
            prev_ss   = ss_n;
        end
    end

    task automatic wait_idle();
        do @(posedge clk); while (idle_cnt < 3);
        #1;
    endtask

    task automatic burst(input int n, input int g, input int d, input bit late,
                         input bit rnd);
        wait_idle();
        cfg_gap = 4'(g);
        cfg_div = 4'(d);
        for (int i = 0; i < n; i++) begin
            if (late && i == 1) begin
                repeat (20) @(posedge clk);
                #1;
            end
            q[wr % 256] = rnd ? 8'($urandom) : 8'(8'hA5 ^ 8'(wr * 3));
            wr++;
        end
        wait_idle();
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        #1;
        chk(ss_n == 1'b1, "R1", "ss_n in reset", ss_n, 1);
        chk(!sclk && !busy, "R1", "sclk/busy in reset", {sclk, busy}, 0);
        chk(!tx_pop && !rx_push, "R1", "strobes in reset", {tx_pop, rx_push}, 0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk(ss_n && !busy && !sclk, "R1", "idle after reset", {ss_n, busy, sclk}, 4);
        run_mon = 1;
        // directed corners
        burst(3, 0, 0, 0, 0);   // R6 continuous, fastest clock
        burst(2, 15, 1, 0, 0);  // R6 largest gap
        burst(1, 2, 3, 0, 0);   // single word, gap unused
        burst(3, 1, 3, 1, 0);   // R7 word queued mid-shift
        burst(2, 0, 2, 1, 0);   // R7 late word, continuous
        // constrained random
        for (int b = 0; b < 14; b++)
            burst(1 + int'($urandom % 4), int'($urandom % 4),
                  int'($urandom % 4), 1'($urandom % 2), 1);
        chk(tx_k == wr, "R7", "words sent", tx_k, wr);
        chk(rx_k == wr, "R5", "words received", rx_k, wr);
        chk(mismatch == 0, "R8", "busy/ss_n/sclk idle agreement", mismatch, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule